// File: doc/BRIEF.md
# Dual-Channel Oscillator Frequency Difference Counter

This block compares a sensing oscillator with a reference oscillator. A single gate window, timed in system clocks, enables both channel counters together. Each channel counter is a ripple chain clocked by its own oscillator. When a mass-loaded sensor's resonance drops, its count falls below the reference count. After the gate closes and a short settle interval passes, both counts are registered into the system clock domain. Their signed difference, sensing minus reference, is then presented together with a one-cycle valid pulse.

A measurement begins with a start pulse. The block then clears both chains, opens the gate for the programmed number of system clocks, waits out the settle interval, and captures the results. If either chain wraps past its maximum during the window, an overflow flag is raised alongside the result. Between measurements the outputs keep the last captured values.

Top module: `freq_diff_counter`

## Requirements
- R1: After reset, valid_o, ovf_o, both counts and the difference are all zero.
- R2: cnt_sns_o equals the number of rising edges of osc_sns_i inside the gate window, within ±3 edges to allow for synchronizer alignment.
- R3: cnt_ref_o equals the number of rising edges of osc_ref_i inside the gate window, within ±3 edges.
- R4: diff_o is the two's complement value cnt_sns_o minus cnt_ref_o, CNT_W+1 bits wide, and it is negative when the reference count is larger.
- R5: A start pulse sampled on clock edge E0 while the block is idle makes valid_o high for exactly one cycle, following edge E0+CLR_CYC+gate_len+SETTLE_CYC. The gate is open from edge E0+CLR_CYC to edge E0+CLR_CYC+gate_len.
- R6: Both chains are cleared at the start of every measurement, so no count carries over from the previous measurement.
- R7: ovf_o is 1 in a result when either chain passed 2^CNT_W-1 during the window. It is 0 in the next result that has no wrap.
- R8: A gate_len of zero opens no gate: the result has both counts and the difference equal to zero, and valid_o follows edge E0+CLR_CYC+SETTLE_CYC.
- R9: A start pulse that arrives while a measurement is in progress is ignored: it produces no extra valid pulse and does not change the result.
- R10: Outputs hold their last captured values in every cycle where valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a measurement (accepted only when idle) |
| gate_len_i | input | GL_W | Gate window length in system clocks |
| osc_sns_i | input | 1 | Sensing oscillator |
| osc_ref_i | input | 1 | Reference oscillator |
| cnt_sns_o | output | CNT_W | Captured sensing count |
| cnt_ref_o | output | CNT_W | Captured reference count |
| diff_o | output | CNT_W+1 | Signed difference, sensing minus reference |
| ovf_o | output | 1 | A chain wrapped during the window |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The bench changes the oscillator rates so that the difference is positive in some runs and negative in others. A design that subtracts in the wrong order, or drops the sign bit, would report a reversed or wrapped value. It runs a zero-length gate, which a design that opens a one-cycle gate would fail by reporting nonzero counts. It runs back-to-back measurements, which expose any chain that does not clear and so accumulates counts. A second instance with narrow counters is made to wrap and then not to wrap, so an overflow flag that sticks, or that never fires, shows up. A start pulse issued in the middle of a measurement checks that a busy block does not restart itself or emit an extra strobe.

// File: rtl/fdc_pkg.sv
// Shared types for the frequency difference counter.
package fdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLEAR  = 2'd1,
        ST_GATE   = 2'd2,
        ST_SETTLE = 2'd3
    } fdc_state_e;
endpackage

// File: rtl/fdc_gate_ctrl.sv
// Measurement sequencer in the system clock domain.
// Walks through clear, gate and settle phases after a start pulse and
// produces glitch-free registered clear and gate levels, plus a capture
// strobe in the last settle cycle.
// Assumes CLR_CYC and SETTLE_CYC are at least 1 and fit in GL_W bits, and
// that SETTLE_CYC covers the oscillator-side synchronizer delay.
module fdc_gate_ctrl
    import fdc_pkg::*;
#(
    parameter int GL_W       = 16,
    parameter int CLR_CYC    = 2,
    parameter int SETTLE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [GL_W-1:0] gate_len_i,
    output logic            clr_o,
    output logic            gate_o,
    output logic            capture_o
);
    localparam logic [GL_W-1:0] CLR_LAST    = GL_W'(CLR_CYC - 1);
    localparam logic [GL_W-1:0] SETTLE_LAST = GL_W'(SETTLE_CYC - 1);

    fdc_state_e      state_q, state_d;
    logic [GL_W-1:0] cnt_q, cnt_d;

    // Next phase and phase counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_CLEAR;
                    cnt_d   = CLR_LAST;
                end
            end
            ST_CLEAR: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (gate_len_i == '0) begin
                    state_d = ST_SETTLE;
                    cnt_d   = SETTLE_LAST;
                end else begin
                    state_d = ST_GATE;
                    cnt_d   = gate_len_i - 1'b1;
                end
            end
            ST_GATE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_SETTLE;
                    cnt_d   = SETTLE_LAST;
                end
            end
            default: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Phase registers and registered clear/gate levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            clr_o   <= 1'b0;
            gate_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            clr_o   <= (state_d == ST_CLEAR);
            gate_o  <= (state_d == ST_GATE);
        end
    end

    // Capture strobe in the last settle cycle.
    assign capture_o = (state_q == ST_SETTLE) && (cnt_q == '0);

    // R6: a gate window always opens straight after a clear phase.
    a_r6_clear_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(clr_o));

    // R9: a clear phase only ever begins from idle.
    a_r9_restart_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_o) |-> ($past(state_q) == ST_IDLE));

    // R8: a zero gate length skips the gate phase entirely.
    a_r8_zero_gate_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && cnt_q == '0 && gate_len_i == '0) |=> !gate_o);

    // Clear and gate are never open together.
    a_r6_clear_gate_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_o && gate_o));
endmodule

// File: rtl/fdc_ripple_counter.sv
// One measurement channel: gate synchronizer plus ripple counter.
// Stage 0 toggles on the oscillator's rising edge while the synchronized
// gate is high. Each later stage toggles on the falling edge of the stage
// before it. A final flop latches a wrap of the top stage.
// Assumes clr_i is a glitch-free level that is held for at least one
// oscillator period while the gate is low. Clear acts asynchronously
// because the upper stages never see the oscillator clock.
module fdc_ripple_counter #(
    parameter int CNT_W  = 20,
    parameter int SYNC_N = 2
) (
    input  logic             osc_i,
    input  logic             clr_i,
    input  logic             gate_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic [SYNC_N-1:0] gate_sync;
    logic [CNT_W-1:0]  stage;

    // Carry the gate level into the oscillator domain.
    always_ff @(posedge osc_i or posedge clr_i) begin
        if (clr_i) gate_sync <= '0;
        else       gate_sync <= {gate_sync[SYNC_N-2:0], gate_i};
    end

    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        logic bit_q;
        if (i == 0) begin : g_first
            // Gated toggle on the oscillator edge.
            always_ff @(posedge osc_i or posedge clr_i) begin
                if (clr_i)                    bit_q <= 1'b0;
                else if (gate_sync[SYNC_N-1]) bit_q <= ~bit_q;
            end
        end else begin : g_next
            // Toggle on the previous stage's falling edge.
            always_ff @(negedge stage[i-1] or posedge clr_i) begin
                if (clr_i) bit_q <= 1'b0;
                else       bit_q <= ~bit_q;
            end
        end
        assign stage[i] = bit_q;
    end

    // Latch a wrap of the top stage.
    always_ff @(negedge stage[CNT_W-1] or posedge clr_i) begin
        if (clr_i) wrap_o <= 1'b0;
        else       wrap_o <= 1'b1;
    end

    assign count_o = stage;
endmodule

// File: rtl/fdc_capture.sv
// Result register in the system clock domain.
// Samples both settled counts on the capture strobe, forms the signed
// difference and raises a one-cycle valid pulse.
// Assumes the counts are static whenever capture_i is high.
module fdc_capture #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [CNT_W-1:0] sns_i,
    input  logic [CNT_W-1:0] ref_i,
    input  logic             wrap_sns_i,
    input  logic             wrap_ref_i,
    output logic [CNT_W-1:0] cnt_sns_o,
    output logic [CNT_W-1:0] cnt_ref_o,
    output logic [CNT_W:0]   diff_o,
    output logic             ovf_o,
    output logic             valid_o
);
    localparam int DIFF_W = CNT_W + 1;

    logic signed [DIFF_W-1:0] diff_d;

    // Signed subtraction on zero-extended counts.
    always_comb begin
        diff_d = $signed({1'b0, sns_i}) - $signed({1'b0, ref_i});
    end

    // Register the result and strobe valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_sns_o <= '0;
            cnt_ref_o <= '0;
            diff_o    <= '0;
            ovf_o     <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= capture_i;
            if (capture_i) begin
                cnt_sns_o <= sns_i;
                cnt_ref_o <= ref_i;
                diff_o    <= diff_d;
                ovf_o     <= wrap_sns_i | wrap_ref_i;
            end
        end
    end

    // R5: the result strobe lasts one cycle.
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R10: outputs hold while no capture is taking place.
    a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> ($stable(cnt_sns_o) && $stable(cnt_ref_o) && $stable(diff_o)));

    // R4: the sign of the difference agrees with the count order.
    a_r4_diff_sign: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (diff_o[CNT_W] == (cnt_sns_o < cnt_ref_o)));
endmodule

// File: rtl/freq_diff_counter.sv
// Dual-channel frequency difference counter.
// A sequencer opens one gate window for two matched ripple channels. After
// a settle interval the counts are captured, and sensing minus reference is
// reported as a signed value.
// Assumes both oscillators keep running through the clear and settle phases.
module freq_diff_counter #(
    parameter int CNT_W      = 20,
    parameter int GL_W       = 16,
    parameter int CLR_CYC    = 2,
    parameter int SETTLE_CYC = 4,
    parameter int SYNC_N     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [GL_W-1:0]  gate_len_i,
    input  logic             osc_sns_i,
    input  logic             osc_ref_i,
    output logic [CNT_W-1:0] cnt_sns_o,
    output logic [CNT_W-1:0] cnt_ref_o,
    output logic [CNT_W:0]   diff_o,
    output logic             ovf_o,
    output logic             valid_o
);
    logic             clr, gate, capture;
    logic [CNT_W-1:0] raw_sns, raw_ref;
    logic             wrap_sns, wrap_ref;

    fdc_gate_ctrl #(
        .GL_W(GL_W), .CLR_CYC(CLR_CYC), .SETTLE_CYC(SETTLE_CYC)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .gate_len_i(gate_len_i),
        .clr_o(clr), .gate_o(gate), .capture_o(capture)
    );

    fdc_ripple_counter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) i_sns (
        .osc_i(osc_sns_i), .clr_i(clr), .gate_i(gate),
        .count_o(raw_sns), .wrap_o(wrap_sns)
    );

    fdc_ripple_counter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) i_ref (
        .osc_i(osc_ref_i), .clr_i(clr), .gate_i(gate),
        .count_o(raw_ref), .wrap_o(wrap_ref)
    );

    fdc_capture #(.CNT_W(CNT_W)) i_cap (
        .clk(clk), .rst_n(rst_n), .capture_i(capture),
        .sns_i(raw_sns), .ref_i(raw_ref),
        .wrap_sns_i(wrap_sns), .wrap_ref_i(wrap_ref),
        .cnt_sns_o(cnt_sns_o), .cnt_ref_o(cnt_ref_o),
        .diff_o(diff_o), .ovf_o(ovf_o), .valid_o(valid_o)
    );
endmodule

// File: tb/test_freq_diff_counter.sv
`timescale 1ns/1ps
module test_freq_diff_counter;
    localparam int CNT_W = 20;
    localparam int SW    = 8;
    localparam int GL_W  = 16;
    localparam int CLRC  = 2;
    localparam int SETC  = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [GL_W-1:0] gate_len = '0;
    logic osc_sns = 1'b0, osc_ref = 1'b0;
    real  sns_half = 1.5, ref_half = 1.7;

    logic [CNT_W-1:0] c_sns, c_ref;
    logic [CNT_W:0]   diff;
    logic             ovf, valid;
    logic [SW-1:0]    s_sns, s_ref;
    logic [SW:0]      s_diff;
    logic             s_ovf, s_valid;

    freq_diff_counter #(.CNT_W(CNT_W), .GL_W(GL_W), .CLR_CYC(CLRC), .SETTLE_CYC(SETC))
    i_freq_diff_counter (
        .clk(clk), .rst_n(rst_n), .start_i(start), .gate_len_i(gate_len),
        .osc_sns_i(osc_sns), .osc_ref_i(osc_ref),
        .cnt_sns_o(c_sns), .cnt_ref_o(c_ref), .diff_o(diff), .ovf_o(ovf), .valid_o(valid)
    );

    freq_diff_counter #(.CNT_W(SW), .GL_W(GL_W), .CLR_CYC(CLRC), .SETTLE_CYC(SETC))
    i_small (
        .clk(clk), .rst_n(rst_n), .start_i(start), .gate_len_i(gate_len),
        .osc_sns_i(osc_sns), .osc_ref_i(osc_ref),
        .cnt_sns_o(s_sns), .cnt_ref_o(s_ref), .diff_o(s_diff), .ovf_o(s_ovf), .valid_o(s_valid)
    );

    always #10 clk = ~clk;
    always #(sns_half) osc_sns = ~osc_sns;
    always #(ref_half) osc_ref = ~osc_ref;

    int vectors = 0, fails = 0;
    int cyc = 0, ws = -1, we = -1, tv = -1;
    int n_sns = 0, n_ref = 0;
    bit win = 1'b0, armed = 1'b0;
    logic [CNT_W-1:0] h_sns = '0, h_ref = '0;
    logic [CNT_W:0]   h_diff = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Model: system edge counter and gate window.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == ws) win = 1'b1;
        if (cyc == we) win = 1'b0;
    end
    always @(posedge osc_sns) if (win) n_sns++;
    always @(posedge osc_ref) if (win) n_ref++;

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (armed && cyc == tv) begin
                chk(valid === 1'b1, "R5 valid at expected cycle", int'(valid), 1);
                chk(c_sns + 3 >= n_sns && c_sns <= n_sns + 3, "R2/R6 sensing count", int'(c_sns), n_sns);
                chk(c_ref + 3 >= n_ref && c_ref <= n_ref + 3, "R3/R6 reference count", int'(c_ref), n_ref);
                chk(int'($signed(diff)) == int'(c_sns) - int'(c_ref), "R4 signed difference",
                    int'($signed(diff)), int'(c_sns) - int'(c_ref));
                chk(ovf === 1'b0, "R7 no wrap in wide channel", int'(ovf), 0);
                chk(s_valid === 1'b1, "R5 narrow valid", int'(s_valid), 1);
                chk(int'($signed(s_diff)) == int'(s_sns) - int'(s_ref), "R4 narrow difference",
                    int'($signed(s_diff)), int'(s_sns) - int'(s_ref));
                if (n_sns > 259 || n_ref > 259)
                    chk(s_ovf === 1'b1, "R7 wrap flagged", int'(s_ovf), 1);
                else if (n_sns < 253 && n_ref < 253)
                    chk(s_ovf === 1'b0, "R7 flag cleared", int'(s_ovf), 0);
                h_sns = c_sns; h_ref = c_ref; h_diff = diff;
                armed = 1'b0;
            end else begin
                chk(valid === 1'b0, "R5/R9 no stray valid", int'(valid), 0);
                chk(c_sns === h_sns && c_ref === h_ref && diff === h_diff, "R10 hold",
                    int'(c_sns), int'(h_sns));
            end
        end
    end

    task automatic measure(input int g);
        @(negedge clk);
        gate_len = GL_W'(g);
        start = 1'b1;
        ws = cyc + 1 + CLRC;
        we = ws + g;
        tv = we + SETC;
        n_sns = 0; n_ref = 0;
        armed = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (cyc > tv + 1);
    endtask

    // R9: start pulse while busy.
    task automatic poke_busy();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(valid === 1'b0 && ovf === 1'b0, "R1 reset flags", int'(valid), 0);
        chk(c_sns === '0 && c_ref === '0 && diff === '0, "R1 reset values", int'(c_sns), 0);

        measure(30);                 // positive difference, no wrap
        measure(60);                 // narrow channel wraps
        measure(30);                 // R7 flag clears, R6 fresh counts
        measure(0);                  // R8 zero gate
        chk(h_sns === '0 && h_ref === '0 && h_diff === '0, "R8 zero gate result", int'(h_sns), 0);
        fork
            measure(40);
            begin repeat (10) @(negedge clk); poke_busy(); end
        join
        sns_half = 1.9;              // R4 negative difference
        repeat (5) @(negedge clk);
        measure(45);
        chk($signed(h_diff) < 0, "R4 negative difference", int'($signed(h_diff)), -1);
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule